// File: doc/BRIEF.md
# Reset cause flag register

This block keeps a record of which event brought the chip out of its most recent reset, and it also holds the trip-level setting of a supply voltage monitor. Three reset sources arrive as single-cycle pulses: power-on, external pin and watchdog. Each one sets a sticky flag, and software reads these flags back through a small synchronous register port. The intended use is for software to read the flags early after boot, then clear them by writing zeros. The next reset then leaves a clean record of its own cause.

The flags clear in an asymmetric way. A power-on event wipes the watchdog and external flags and raises its own flag. The power-on flag itself goes away only when software writes a zero to it.

The second register selects how a trip from the external voltage comparator is handled. One level code turns a trip into a power-on reset request. A range of higher codes latches a monitor flag instead, and that flag can raise an interrupt. The remaining codes disable the monitor. Internally, a decoder maps the level code to one of three named modes: `MODE_OFF`, `MODE_RESET` and `MODE_FLAG`. The mode is re-evaluated every cycle from the stored level.

Top module: `rcause_regs`

## Requirements
- R1: The cause register is read at address 0x3B. Bit 3 is the watchdog flag, bit 1 is the external flag and bit 0 is the power-on flag. Bits 7:4 and bit 2 read as zero. Any address other than 0x3B and 0x3A reads as 0x00. Reads are combinational from `bus_addr`.
- R2: A `wdt_evt` pulse sets bit 3 and an `ext_evt` pulse sets bit 1 at the next clock edge. Each flag then holds until it is cleared.
- R3: A write to 0x3B clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. Writes to reserved bits have no effect.
- R4: A `por_evt` pulse leaves the cause register at exactly 0x01 after the next edge. The same edge resets the monitor level to 000, the interrupt enable to 0 and the monitor flag to 0. A register write in the same cycle is ignored.
- R5: When a watchdog or external event arrives in the same cycle as a write of 0 to its bit, the flag ends up set.
- R6: The power-on flag is cleared only by a write of 0 to bit 0. Watchdog and external events leave it unchanged.
- R7: The monitor register is read and written at address 0x3A. Bits 2:0 hold the level code, bit 5 is the interrupt enable, bit 6 is the monitor flag, and the other bits read zero.
- R8: With level code 000, 110 or 111, a `vlm_trip` raises neither `por_req` nor the monitor flag.
- R9: With level code 001, `por_req` is high in the same cycle as `vlm_trip`, and the monitor flag is not set.
- R10: With level codes 010 through 101, a `vlm_trip` sets the monitor flag at the next edge and leaves `por_req` low.
- R11: `irq` equals the monitor flag AND the enable bit. Writing 1 to bit 6 clears the flag and writing 0 to it has no effect. A trip in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on reset event pulse |
| ext_evt | input | 1 | External reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| vlm_trip | input | 1 | Voltage comparator trip pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| por_req | output | 1 | Power-on reset request from the monitor |
| irq | output | 1 | Monitor interrupt request |

## Verification
The bench goes after the cases where priority decides the result. The first is an event arriving in the same cycle as a write of zero. A design that lets the write win would lose a reset cause. The second is a power-on event arriving together with a register write. Here a leaky design would keep stale watchdog or external flags, or accept the write. The bench also trips the monitor at every level code, including the two forbidden ones. A wrong decode would either request a reset where only a flag is due, or react while the monitor is meant to be off. Finally, it clears the monitor flag with a write of 1 in the same cycle as a new trip, and checks that `irq` follows the enable bit.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
    localparam int unsigned LVL_W  = 3;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RESET = 2'd1,
        MODE_FLAG  = 2'd2
    } mon_mode_e;
endpackage

// File: rtl/rcause_decode.sv
module rcause_decode
    import rcause_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    output mon_mode_e        mode
);
    always_comb begin
        unique case (level)
            3'd1:                      mode = MODE_RESET;
            3'd2, 3'd3, 3'd4, 3'd5:    mode = MODE_FLAG;
            default:                   mode = MODE_OFF;
        endcase
    end
endmodule

// File: rtl/rcause_flags.sv
module rcause_flags
    import rcause_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 6,
    parameter logic [ADDR_W-1:0]  FLAG_ADDR = 6'h3B
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              wdt_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [2:0]        flags      // {watchdog, external, power-on}
);
    localparam int unsigned NFLAG = 3;

    logic             hit;
    logic [NFLAG-1:0] set_evt;
    logic [NFLAG-1:0] wr_keep;

    assign hit     = wr_en && (wr_addr == FLAG_ADDR);
    assign set_evt = {wdt_evt, ext_evt, 1'b0};
    assign wr_keep = {wr_data[3], wr_data[1], wr_data[0]};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam logic POR_VAL = (i == 0) ? 1'b1 : 1'b0;
        always_ff @(posedge clk) begin
            if (por_evt) begin
                flags[i] <= POR_VAL;
            end else if (set_evt[i]) begin
                flags[i] <= 1'b1;
            end else if (hit && !wr_keep[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rcause_monitor.sv
module rcause_monitor
    import rcause_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 6,
    parameter logic [ADDR_W-1:0]  MON_ADDR = 6'h3A
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              trip,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LVL_W-1:0]  level,
    output logic              ie,
    output logic              flag,
    output logic              por_req
);
    localparam int unsigned IE_BIT   = 5;
    localparam int unsigned FLAG_BIT = 6;

    mon_mode_e mode;
    logic      hit;

    rcause_decode u_dec (
        .level (level),
        .mode  (mode)
    );

    assign hit = wr_en && (wr_addr == MON_ADDR);

    always_ff @(posedge clk) begin
        if (por_evt) begin
            level <= '0;
            ie    <= 1'b0;
        end else if (hit) begin
            level <= wr_data[LVL_W-1:0];
            ie    <= wr_data[IE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (por_evt) begin
            flag <= 1'b0;
        end else if (trip && (mode == MODE_FLAG)) begin
            flag <= 1'b1;
        end else if (hit && wr_data[FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_RESET: por_req = trip;
            MODE_FLAG:  por_req = 1'b0;
            default:    por_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/rcause_regs.sv
module rcause_regs
    import rcause_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 6,
    parameter logic [ADDR_W-1:0]  FLAG_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0]  MON_ADDR  = 6'h3A
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              wdt_evt,
    input  logic              vlm_trip,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              por_req,
    output logic              irq
);
    logic [2:0]       flag_vec;
    logic [LVL_W-1:0] mon_level;
    logic             mon_ie;
    logic             mon_flag;

    rcause_flags #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_flags (
        .clk     (clk),
        .por_evt (por_evt),
        .ext_evt (ext_evt),
        .wdt_evt (wdt_evt),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .flags   (flag_vec)
    );

    rcause_monitor #(.ADDR_W(ADDR_W), .MON_ADDR(MON_ADDR)) u_mon (
        .clk     (clk),
        .por_evt (por_evt),
        .trip    (vlm_trip),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .level   (mon_level),
        .ie      (mon_ie),
        .flag    (mon_flag),
        .por_req (por_req)
    );

    assign irq = mon_flag & mon_ie;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == FLAG_ADDR) begin
            bus_rdata = {4'b0000, flag_vec[2], 1'b0, flag_vec[1], flag_vec[0]};
        end else if (bus_addr == MON_ADDR) begin
            bus_rdata = {1'b0, mon_flag, mon_ie, 2'b00, mon_level};
        end
    end
endmodule

// File: rtl/rcause_checker.sv
module rcause_checker #(
    parameter int unsigned ADDR_W = 6
) (
    input logic       clk,
    input logic       por_evt,
    input logic       ext_evt,
    input logic       wdt_evt,
    input logic       vlm_trip,
    input logic       bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       por_req,
    input logic       irq,
    input logic [2:0] flag_vec,
    input logic [2:0] mon_level,
    input logic       mon_ie,
    input logic       mon_flag
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= armed | por_evt;

    p_por_result_r4: assert property (@(posedge clk) disable iff (!armed)
        por_evt |=> (flag_vec == 3'b001 && mon_level == 3'd0 && !mon_flag && !mon_ie));

    p_wdt_set_r2: assert property (@(posedge clk) disable iff (!armed)
        (wdt_evt && !por_evt) |=> flag_vec[2]);

    p_ext_set_r5: assert property (@(posedge clk) disable iff (!armed)
        (ext_evt && !por_evt) |=> flag_vec[1]);

    p_por_sticky_r6: assert property (@(posedge clk) disable iff (!armed)
        (flag_vec[0] && !por_evt && !(bus_wr && bus_addr == 6'h3B && !bus_wdata[0]))
        |=> flag_vec[0]);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!armed)
        (vlm_trip && (mon_level == 3'd0 || mon_level > 3'd5)) |-> !por_req);

    p_reset_level_r9: assert property (@(posedge clk) disable iff (!armed)
        (vlm_trip && mon_level == 3'd1) |-> por_req);

    p_flag_level_r10: assert property (@(posedge clk) disable iff (!armed)
        (vlm_trip && !por_evt && mon_level >= 3'd2 && mon_level <= 3'd5) |=> mon_flag);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!armed)
        irq |-> (mon_ie && mon_flag));
endmodule

bind rcause_regs rcause_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .por_evt   (por_evt),
    .ext_evt   (ext_evt),
    .wdt_evt   (wdt_evt),
    .vlm_trip  (vlm_trip),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .por_req   (por_req),
    .irq       (irq),
    .flag_vec  (flag_vec),
    .mon_level (mon_level),
    .mon_ie    (mon_ie),
    .mon_flag  (mon_flag)
);

// File: tb/rcause_regs_tb_top.sv
module rcause_regs_tb_top;
    logic       clk = 1'b0;
    logic       por_evt = 1'b0, ext_evt = 1'b0, wdt_evt = 1'b0, vlm_trip = 1'b0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = 6'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       por_req, irq;

    always #2 clk = ~clk;

    rcause_regs dut_i (
        .clk(clk), .por_evt(por_evt), .ext_evt(ext_evt), .wdt_evt(wdt_evt),
        .vlm_trip(vlm_trip), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .por_req(por_req), .irq(irq)
    );

    // behavioural reference state
    int m_wd, m_ex, m_po, m_lvl, m_ie, m_mf;
    bit m_valid = 0;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    function automatic int exp_rdata();
        if (bus_addr == 6'h3B) return m_wd * 8 + m_ex * 2 + m_po;
        if (bus_addr == 6'h3A) return m_mf * 64 + m_ie * 32 + m_lvl;
        return 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int lvl_now = m_lvl;
        if (por_evt) begin
            m_wd = 0; m_ex = 0; m_po = 1; m_lvl = 0; m_ie = 0; m_mf = 0;
            m_valid = 1;
            return;
        end
        if (bus_wr && bus_addr == 6'h3B) begin
            if (!bus_wdata[3]) m_wd = 0;
            if (!bus_wdata[1]) m_ex = 0;
            if (!bus_wdata[0]) m_po = 0;
        end
        if (wdt_evt) m_wd = 1;
        if (ext_evt) m_ex = 1;
        if (bus_wr && bus_addr == 6'h3A) begin
            m_lvl = int'(bus_wdata[2:0]);
            m_ie  = int'(bus_wdata[5]);
            if (bus_wdata[6]) m_mf = 0;
        end
        if (vlm_trip && lvl_now >= 2 && lvl_now <= 5) m_mf = 1;
    endtask

    // one clock: compare outputs for current inputs, then advance model
    task automatic cyc(string tag);
        #1;
        if (m_valid) begin
            chk(tag, "rdata", int'(bus_rdata), exp_rdata());
            chk(tag, "por_req", int'(por_req), (vlm_trip && m_lvl == 1) ? 1 : 0);
            chk(tag, "irq", int'(irq), m_mf & m_ie);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        por_evt = 0; ext_evt = 0; wdt_evt = 0; vlm_trip = 0; bus_wr = 0;
    endtask

    task automatic wr(string tag, logic [5:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc(tag);
    endtask

    task automatic rd(string tag, logic [5:0] a);
        bus_addr = a;
        cyc(tag);
    endtask

    initial begin
        @(negedge clk);
        // R4: first power-on
        por_evt = 1; cyc("R4");
        rd("R4", 6'h3B); rd("R1", 6'h3B); rd("R7", 6'h3A); rd("R1", 6'h10);
        // R2: events set flags; R6: power-on flag kept
        wdt_evt = 1; bus_addr = 6'h3B; cyc("R2");
        rd("R2", 6'h3B);
        ext_evt = 1; cyc("R6");
        rd("R6", 6'h3B);
        // R3: write ones keeps, write zero clears selected bits
        wr("R3", 6'h3B, 8'hFF); rd("R3", 6'h3B);
        wr("R3", 6'h3B, 8'hF5); rd("R3", 6'h3B);
        wr("R6", 6'h3B, 8'hFE); rd("R6", 6'h3B);
        // R5: set beats write zero
        wdt_evt = 1; ext_evt = 1; wr("R5", 6'h3B, 8'h00); rd("R5", 6'h3B);
        // R4: power-on with a same-cycle write and events
        por_evt = 1; wdt_evt = 1; ext_evt = 1; wr("R4", 6'h3B, 8'hFF); rd("R4", 6'h3B);
        wr("R4", 6'h3A, 8'h25); por_evt = 1; wr("R4", 6'h3A, 8'h24); rd("R4", 6'h3A);
        // R7: monitor register layout, reserved bits zero
        wr("R7", 6'h3A, 8'h9F); rd("R7", 6'h3A);
        // R8: disabled codes
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 6) begin
                wr("R8", 6'h3A, 8'(c)); vlm_trip = 1; cyc("R8"); rd("R8", 6'h3A);
            end
        end
        // R9: reset request level
        wr("R9", 6'h3A, 8'h21); vlm_trip = 1; bus_addr = 6'h3A; cyc("R9"); rd("R9", 6'h3A);
        // R10: flag levels, interrupt disabled
        for (int c = 2; c <= 5; c++) begin
            wr("R10", 6'h3A, 8'h40 | 8'(c)); vlm_trip = 1; cyc("R10"); rd("R10", 6'h3A);
        end
        // R11: irq follows enable; clear rules
        wr("R11", 6'h3A, 8'h23); rd("R11", 6'h3A);
        wr("R11", 6'h3A, 8'h03); rd("R11", 6'h3A);
        wr("R11", 6'h3A, 8'h23); vlm_trip = 1; wr("R11", 6'h3A, 8'h63); rd("R11", 6'h3A);
        wr("R11", 6'h3A, 8'h63); rd("R11", 6'h3A);
        rd("R1", 6'h3B);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule